// File: doc/BRIEF.md
# Committed Store Writeback Queue

This block is the store side of a load/store unit in an out-of-order core. Stores take a slot in program order and carry a sequence number with them. When a store executes, its address, data and byte size are written into its slot. The commit stage then names the youngest sequence number that has retired. Every older store up to that point becomes eligible for writeback. Eligible stores leave in allocation order through a single data-cache request port, which uses a valid/ready handshake and a retry pulse.

A response from the cache names the slot that has finished. The oldest slot is released when it finishes, together with any run of finished slots directly behind it. A squash trims speculative stores from the young end of the queue and never removes a store that has already been committed. The block also reports how many new memory operations the core may dispatch. This figure takes the occupancy of a companion load queue into account.

The ring has one spare slot, so a queue of usable capacity N uses N+1 slots. It keeps three pointers: a release pointer (the oldest slot), a writeback pointer (the next store to send) and an allocation pointer (the next free slot).

Top module: `store_wb_queue`

## Requirements
- R1: The queue holds at most SQ_DEPTH stores. `sq_full` is 1 exactly when `sq_used` equals SQ_DEPTH, and an allocation request while full changes nothing. `alloc_idx` shows the slot that the next allocation takes. Slots are handed out in ascending order and wrap modulo SQ_DEPTH+1.
- R2: A commit request walks from the oldest store toward the youngest. It marks each store whose sequence number is not greater than `commit_seq`, skips stores that are already marked, and stops at the first unmarked store with a larger number.
- R3: `req_valid` is 1 only when the store at the writeback pointer has executed, is marked, and has a nonzero size. `req_addr`, `req_data`, `req_size` and `req_idx` carry that store. Stores are presented one per cycle in allocation order, and the pointer advances on the clock edge where both `req_valid` and `req_ready` are 1.
- R4: A request seen with `req_ready` at 0 sets `wb_blocked` from the next cycle. While it is blocked and `cache_retry` is 0, `req_valid` stays 0. In a cycle with `cache_retry` at 1, the same store is presented again. Acceptance clears `wb_blocked` and advances the pointer.
- R5: A marked store whose size is 0 produces no request. It is marked finished and skipped in one cycle, and its slot is released without any cache response.
- R6: `resp_valid` with `resp_idx` marks that slot finished at the clock edge. At the following edge the oldest pointer skips the whole run of finished slots at the old end in one step, and `sq_used` falls by the length of that run. A finished slot that is not the oldest waits.
- R7: A squash walks from the youngest store toward the oldest. It removes each store whose sequence number is greater than `squash_seq`, and stops at the first marked store or the first store that is not younger. The allocation pointer moves back by the number removed, and an allocation request in the same cycle is ignored.
- R8: When commit and squash arrive in the same cycle, the commit takes effect first. Stores committed in that cycle therefore survive the squash.
- R9: `free_cnt` equals min(LQ_DEPTH+1-`lq_used`, SQ_DEPTH+1-`sq_used`) minus 1.
- R10: After reset the queue is empty, every pointer is at slot 0, `req_valid` and `wb_blocked` are 0, and `free_cnt` follows R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a slot for a new store |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_idx | output | IDX_W | Slot the next allocation takes |
| sq_full | output | 1 | Queue holds SQ_DEPTH stores |
| sq_used | output | CNT_W | Stores currently held |
| exec_valid | input | 1 | Record execution results for a slot |
| exec_idx | input | IDX_W | Slot being executed |
| exec_addr | input | ADDR_W | Store address |
| exec_data | input | DATA_W | Store data |
| exec_size | input | SIZE_W | Store size in bytes, 0 means no write |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| req_valid | output | 1 | Store write presented to the cache |
| req_ready | input | 1 | Cache accepts the presented write |
| req_idx | output | IDX_W | Slot of the presented write |
| req_addr | output | ADDR_W | Address of the presented write |
| req_data | output | DATA_W | Data of the presented write |
| req_size | output | SIZE_W | Size of the presented write |
| cache_retry | input | 1 | Cache can take a refused write again |
| wb_blocked | output | 1 | A refused write is waiting for retry |
| resp_valid | input | 1 | Cache finished a write |
| resp_idx | input | IDX_W | Slot whose write finished |
| lq_used | input | LQC_W | Occupancy of the companion load queue |
| free_cnt | output | CNT_W | Memory operations that may still be dispatched |

## Verification
The most delicate overlap is a commit and a squash in the same cycle. The squash has to see the marks that the commit is setting at that very edge. Otherwise a just-retired store would be thrown away. The bench provokes this with a directed case, committing sequence 12 while squashing above 11, and checks that exactly one store leaves and that the next write presented is the one for sequence 12. Random rounds then pick independent commit and squash points in one cycle. They compare `sq_used` with a model of the survivors, and they check that every committed store with a nonzero size reaches the cache port in program order under random refusals and retries.

// File: rtl/swq_pkg.sv
package swq_pkg;

  typedef enum logic [1:0] {
    WB_IDLE = 2'd0,
    WB_SKIP = 2'd1,
    WB_SEND = 2'd2,
    WB_HOLD = 2'd3
  } wb_act_e;

  function automatic int ring_step(input int p, input int delta, input int slots);
    return (p + delta) % slots;
  endfunction

  function automatic int ring_back(input int p, input int delta, input int slots);
    return (p + slots - delta) % slots;
  endfunction

  function automatic int ring_dist(input int from_p, input int to_p, input int slots);
    return (to_p + slots - from_p) % slots;
  endfunction

  function automatic int free_slots(input int lq_cap, input int lq_used,
                                    input int sq_cap, input int sq_used);
    int lq_free;
    int sq_free;
    lq_free = lq_cap + 1 - lq_used;
    sq_free = sq_cap + 1 - sq_used;
    return ((lq_free < sq_free) ? lq_free : sq_free) - 1;
  endfunction

endpackage

// File: rtl/swq_commit_scan.sv
module swq_commit_scan
  import swq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3,
  parameter int SEQ_W = 8
) (
  input  logic [IDX_W-1:0] head_i,
  input  logic [CNT_W-1:0] used_i,
  input  logic [SLOTS-1:0] elig_i,
  input  logic [SEQ_W-1:0] seq_i [SLOTS],
  input  logic             commit_i,
  input  logic [SEQ_W-1:0] commit_seq_i,
  output logic [SLOTS-1:0] mark_o
);

  always_comb begin
    logic             go;
    logic [IDX_W-1:0] idx;
    mark_o = '0;
    go     = commit_i;
    for (int k = 0; k < SLOTS; k++) begin
      idx = IDX_W'(ring_step(int'(head_i), k, SLOTS));
      if (go && (k < int'(used_i)) && !elig_i[idx]) begin
        if (seq_i[idx] <= commit_seq_i) mark_o[idx] = 1'b1;
        else                            go = 1'b0;
      end
    end
  end

endmodule

// File: rtl/swq_squash_walk.sv
module swq_squash_walk
  import swq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3,
  parameter int SEQ_W = 8
) (
  input  logic [IDX_W-1:0] tail_i,
  input  logic [CNT_W-1:0] used_i,
  input  logic [SLOTS-1:0] elig_i,
  input  logic [SEQ_W-1:0] seq_i [SLOTS],
  input  logic             squash_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic [SLOTS-1:0] kill_o,
  output logic [CNT_W-1:0] kill_cnt_o
);

  always_comb begin
    logic             go;
    logic [IDX_W-1:0] idx;
    int               cnt;
    kill_o = '0;
    cnt    = 0;
    go     = squash_i;
    for (int k = 0; k < SLOTS; k++) begin
      idx = IDX_W'(ring_back(int'(tail_i), k + 1, SLOTS));
      if (go && (k < int'(used_i))) begin
        if (elig_i[idx] || (seq_i[idx] <= squash_seq_i)) begin
          go = 1'b0;
        end else begin
          kill_o[idx] = 1'b1;
          cnt         = cnt + 1;
        end
      end
    end
    kill_cnt_o = CNT_W'(cnt);
  end

endmodule

// File: rtl/swq_head_walk.sv
module swq_head_walk
  import swq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input  logic [IDX_W-1:0] head_i,
  input  logic [CNT_W-1:0] used_i,
  input  logic [SLOTS-1:0] done_i,
  output logic [SLOTS-1:0] pass_o,
  output logic [CNT_W-1:0] adv_o
);

  always_comb begin
    logic             go;
    logic [IDX_W-1:0] idx;
    int               cnt;
    pass_o = '0;
    cnt    = 0;
    go     = 1'b1;
    for (int k = 0; k < SLOTS; k++) begin
      idx = IDX_W'(ring_step(int'(head_i), k, SLOTS));
      if (go && (k < int'(used_i)) && done_i[idx]) begin
        pass_o[idx] = 1'b1;
        cnt         = cnt + 1;
      end else begin
        go = 1'b0;
      end
    end
    adv_o = CNT_W'(cnt);
  end

endmodule

// File: rtl/store_wb_queue.sv
module store_wb_queue
  import swq_pkg::*;
#(
  parameter int SQ_DEPTH = 4,
  parameter int LQ_DEPTH = 6,
  parameter int SEQ_W    = 8,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int SIZE_W   = 4,
  localparam int SLOTS   = SQ_DEPTH + 1,
  localparam int IDX_W   = $clog2(SLOTS),
  localparam int CNT_W   = $clog2(SLOTS + 1),
  localparam int LQC_W   = $clog2(LQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic              sq_full,
  output logic [CNT_W-1:0]  sq_used,
  input  logic              exec_valid,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [DATA_W-1:0] exec_data,
  input  logic [SIZE_W-1:0] exec_size,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IDX_W-1:0]  req_idx,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [SIZE_W-1:0] req_size,
  input  logic              cache_retry,
  output logic              wb_blocked,
  input  logic              resp_valid,
  input  logic [IDX_W-1:0]  resp_idx,
  input  logic [LQC_W-1:0]  lq_used,
  output logic [CNT_W-1:0]  free_cnt
);

  // ---------------- state ----------------
  logic [IDX_W-1:0]  head_q, tail_q, wbp_q;
  logic              blocked_q;
  logic [SLOTS-1:0]  valid_q, execd_q, elig_q, done_q;
  logic [SEQ_W-1:0]  seq_q  [SLOTS];
  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic [DATA_W-1:0] data_q [SLOTS];
  logic [SIZE_W-1:0] size_q [SLOTS];

  // ---------------- named internal events ----------------
  logic [CNT_W-1:0]  used;
  logic [SLOTS-1:0]  commit_mark, elig_next;
  logic [SLOTS-1:0]  kill_mask, head_pass;
  logic [CNT_W-1:0]  kill_cnt, head_adv;
  logic              alloc_ok;
  logic              wb_pending;
  wb_act_e           wb_act;
  logic              wb_accept, wb_refuse;

  assign used      = CNT_W'(ring_dist(int'(head_q), int'(tail_q), SLOTS));
  assign sq_used   = used;
  assign sq_full   = (used == CNT_W'(SQ_DEPTH));
  assign alloc_idx = tail_q;
  assign free_cnt  = CNT_W'(free_slots(LQ_DEPTH, int'(lq_used), SQ_DEPTH, int'(used)));
  assign alloc_ok  = alloc_valid && !sq_full && !squash_valid;

  // commit marks first; the squash walk sees them (commit before squash)
  swq_commit_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_commit (
    .head_i       (head_q),
    .used_i       (used),
    .elig_i       (elig_q),
    .seq_i        (seq_q),
    .commit_i     (commit_valid),
    .commit_seq_i (commit_seq),
    .mark_o       (commit_mark)
  );

  assign elig_next = elig_q | commit_mark;

  swq_squash_walk #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_squash (
    .tail_i       (tail_q),
    .used_i       (used),
    .elig_i       (elig_next),
    .seq_i        (seq_q),
    .squash_i     (squash_valid),
    .squash_seq_i (squash_seq),
    .kill_o       (kill_mask),
    .kill_cnt_o   (kill_cnt)
  );

  swq_head_walk #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_head (
    .head_i (head_q),
    .used_i (used),
    .done_i (done_q),
    .pass_o (head_pass),
    .adv_o  (head_adv)
  );

  // ---------------- writeback selection ----------------
  assign wb_pending = (wbp_q != tail_q) && valid_q[wbp_q] && elig_q[wbp_q] && execd_q[wbp_q];

  always_comb begin
    if (!wb_pending)                   wb_act = WB_IDLE;
    else if (size_q[wbp_q] == '0)      wb_act = WB_SKIP;
    else if (blocked_q && !cache_retry) wb_act = WB_HOLD;
    else                               wb_act = WB_SEND;
  end

  assign req_valid  = (wb_act == WB_SEND);
  assign wb_accept  = req_valid && req_ready;
  assign wb_refuse  = req_valid && !req_ready;
  assign req_idx    = wbp_q;
  assign req_addr   = addr_q[wbp_q];
  assign req_data   = data_q[wbp_q];
  assign req_size   = size_q[wbp_q];
  assign wb_blocked = blocked_q;

  // ---------------- sequential update ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q    <= '0;
      tail_q    <= '0;
      wbp_q     <= '0;
      blocked_q <= 1'b0;
      valid_q   <= '0;
      execd_q   <= '0;
      elig_q    <= '0;
      done_q    <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        seq_q[i]  <= '0;
        addr_q[i] <= '0;
        data_q[i] <= '0;
        size_q[i] <= '0;
      end
    end else begin
      head_q <= IDX_W'(ring_step(int'(head_q), int'(head_adv), SLOTS));

      if (squash_valid)  tail_q <= IDX_W'(ring_back(int'(tail_q), int'(kill_cnt), SLOTS));
      else if (alloc_ok) tail_q <= IDX_W'(ring_step(int'(tail_q), 1, SLOTS));

      if (wb_accept || (wb_act == WB_SKIP))
        wbp_q <= IDX_W'(ring_step(int'(wbp_q), 1, SLOTS));

      if (wb_accept)      blocked_q <= 1'b0;
      else if (wb_refuse) blocked_q <= 1'b1;

      for (int i = 0; i < SLOTS; i++) begin
        if (head_pass[i] || kill_mask[i]) begin
          valid_q[i] <= 1'b0;
          execd_q[i] <= 1'b0;
          elig_q[i]  <= 1'b0;
          done_q[i]  <= 1'b0;
        end else if (alloc_ok && (tail_q == IDX_W'(i))) begin
          valid_q[i] <= 1'b1;
          execd_q[i] <= 1'b0;
          elig_q[i]  <= 1'b0;
          done_q[i]  <= 1'b0;
          seq_q[i]   <= alloc_seq;
        end else begin
          if (exec_valid && (exec_idx == IDX_W'(i)) && valid_q[i]) begin
            execd_q[i] <= 1'b1;
            addr_q[i]  <= exec_addr;
            data_q[i]  <= exec_data;
            size_q[i]  <= exec_size;
          end
          elig_q[i] <= elig_next[i];
          if ((resp_valid && (resp_idx == IDX_W'(i)) && valid_q[i]) ||
              ((wb_act == WB_SKIP) && (wbp_q == IDX_W'(i))))
            done_q[i] <= 1'b1;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  assert_used_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CNT_W'(SQ_DEPTH));

  assert_full_no_alloc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_full && alloc_valid && !squash_valid) |=> (tail_q == $past(tail_q)));

  assert_wb_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ring_dist(int'(head_q), int'(wbp_q), SLOTS) <= int'(used));

  assert_refuse_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> wb_blocked);

  assert_hold_while_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_blocked && !cache_retry) |-> !req_valid);

  assert_zero_size_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_act == WB_SKIP) |=> done_q[$past(wbp_q)]);

  assert_pass_only_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (head_pass & ~done_q) == '0);

  assert_no_committed_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_mask & elig_next) == '0);

endmodule

// File: tb/tb_store_wb_queue.sv
module tb_store_wb_queue;

  localparam int DEPTH  = 4;
  localparam int LQD    = 6;
  localparam int SEQ_W  = 8;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SIZE_W = 4;
  localparam int IDX_W  = 3;
  localparam int CNT_W  = 3;
  localparam int LQC_W  = 3;

  // {lq_used, expected free_cnt} with two stores held
  localparam int FREE_TAB [5][2] = '{'{0, 2}, '{3, 2}, '{4, 2}, '{5, 1}, '{6, 0}};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alloc_valid;
  logic [SEQ_W-1:0]  alloc_seq;
  logic [IDX_W-1:0]  alloc_idx;
  logic              sq_full;
  logic [CNT_W-1:0]  sq_used;
  logic              exec_valid;
  logic [IDX_W-1:0]  exec_idx;
  logic [ADDR_W-1:0] exec_addr;
  logic [DATA_W-1:0] exec_data;
  logic [SIZE_W-1:0] exec_size;
  logic              commit_valid;
  logic [SEQ_W-1:0]  commit_seq;
  logic              squash_valid;
  logic [SEQ_W-1:0]  squash_seq;
  logic              req_valid;
  logic              req_ready;
  logic [IDX_W-1:0]  req_idx;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic [SIZE_W-1:0] req_size;
  logic              cache_retry;
  logic              wb_blocked;
  logic              resp_valid;
  logic [IDX_W-1:0]  resp_idx;
  logic [LQC_W-1:0]  lq_used;
  logic [CNT_W-1:0]  free_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  store_wb_queue #(.SQ_DEPTH(DEPTH), .LQ_DEPTH(LQD), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
                   .DATA_W(DATA_W), .SIZE_W(SIZE_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_idx(alloc_idx),
    .sq_full(sq_full), .sq_used(sq_used),
    .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
    .exec_data(exec_data), .exec_size(exec_size),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
    .req_addr(req_addr), .req_data(req_data), .req_size(req_size),
    .cache_retry(cache_retry), .wb_blocked(wb_blocked),
    .resp_valid(resp_valid), .resp_idx(resp_idx),
    .lq_used(lq_used), .free_cnt(free_cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    alloc_valid  = 1'b0;
    exec_valid   = 1'b0;
    commit_valid = 1'b0;
    squash_valid = 1'b0;
    cache_retry  = 1'b0;
    resp_valid   = 1'b0;
  endtask

  task automatic do_alloc(input int seq, output logic [IDX_W-1:0] idx);
    idx         = alloc_idx;
    alloc_valid = 1'b1;
    alloc_seq   = SEQ_W'(seq);
    step();
  endtask

  task automatic do_exec(input logic [IDX_W-1:0] idx, input int addr, input int data,
                         input int size);
    exec_valid = 1'b1;
    exec_idx   = idx;
    exec_addr  = ADDR_W'(addr);
    exec_data  = DATA_W'(data);
    exec_size  = SIZE_W'(size);
    step();
  endtask

  task automatic do_resp(input logic [IDX_W-1:0] idx);
    resp_valid = 1'b1;
    resp_idx   = idx;
    step();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R3 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [IDX_W-1:0] ix;
    logic [IDX_W-1:0] slot [4];
    rst_n = 1'b0;
    alloc_valid = 0; alloc_seq = 0; exec_valid = 0; exec_idx = 0; exec_addr = 0;
    exec_data = 0; exec_size = 0; commit_valid = 0; commit_seq = 0; squash_valid = 0;
    squash_seq = 0; req_ready = 0; cache_retry = 0; resp_valid = 0; resp_idx = 0;
    lq_used = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10 used", int'(sq_used), 0);
    chk("R10 req_valid", int'(req_valid), 0);
    chk("R10 blocked", int'(wb_blocked), 0);
    chk("R10 alloc_idx", int'(alloc_idx), 0);
    chk("R9 free at reset", int'(free_cnt), 4);

    // R9 table walk with two stores held
    do_alloc(1, ix);
    do_alloc(2, ix);
    foreach (FREE_TAB[v]) begin
      lq_used = LQC_W'(FREE_TAB[v][0]);
      #1;
      chk("R9 free_cnt", int'(free_cnt), FREE_TAB[v][1]);
    end
    lq_used = 0;
    // R7 squash removes both; allocation in that cycle is ignored
    squash_valid = 1'b1; squash_seq = 0; alloc_valid = 1'b1; alloc_seq = 3;
    step(); #1;
    chk("R7 squash all used", int'(sq_used), 0);
    chk("R7 alloc ignored in squash", int'(alloc_idx), 0);

    // R1 fill
    for (int i = 0; i < 4; i++) do_alloc(10 + i, slot[i]);
    #1;
    chk("R1 used full", int'(sq_used), 4);
    chk("R1 full flag", int'(sq_full), 1);
    chk("R1 slot order", int'(slot[3]), 3);
    do_alloc(14, ix); #1;
    chk("R1 alloc while full used", int'(sq_used), 4);
    chk("R1 alloc while full idx", int'(alloc_idx), 4);
    for (int i = 0; i < 4; i++) do_exec(slot[i], 'h100 + i, 'hA0 + i, 4);
    #1;
    chk("R2 nothing committed", int'(req_valid), 0);

    // R2/R3/R4 commit through 11, refuse then retry
    req_ready = 1'b0;
    commit_valid = 1'b1; commit_seq = 11;
    step(); #1;
    chk("R3 req_valid", int'(req_valid), 1);
    chk("R3 req_addr oldest", int'(req_addr), 'h100);
    chk("R3 req_data", int'(req_data), 'hA0);
    step(); #1;
    chk("R4 blocked after refuse", int'(wb_blocked), 1);
    chk("R4 no req while blocked", int'(req_valid), 0);
    cache_retry = 1'b1; req_ready = 1'b1; #1;
    chk("R4 resend on retry", int'(req_valid), 1);
    chk("R4 resend addr", int'(req_addr), 'h100);
    step(); #1;
    chk("R3 next in order", int'(req_addr), 'h101);
    chk("R4 unblocked", int'(wb_blocked), 0);
    step(); #1;
    chk("R2 scan stops at 12", int'(req_valid), 0);

    // R8 commit 12 and squash above 11 in one cycle
    commit_valid = 1'b1; commit_seq = 12; squash_valid = 1'b1; squash_seq = 11;
    step(); #1;
    chk("R8 committed survives", int'(sq_used), 3);
    chk("R8 req for seq 12", int'(req_addr), 'h102);
    chk("R7 tail moved back", int'(alloc_idx), 3);
    step();

    // R6 completions out of order
    do_resp(slot[1]);
    step(); #1;
    chk("R6 head waits", int'(sq_used), 3);
    do_resp(slot[0]); #1;
    chk("R6 one cycle lag", int'(sq_used), 3);
    step(); #1;
    chk("R6 skip run of two", int'(sq_used), 1);
    do_resp(slot[2]);
    step(); #1;
    chk("R6 empty", int'(sq_used), 0);

    // R5 zero-size store
    do_alloc(20, slot[0]);
    do_alloc(21, slot[1]);
    do_exec(slot[0], 'h200, 0, 0);
    do_exec(slot[1], 'h201, 'h55, 4);
    commit_valid = 1'b1; commit_seq = 21;
    step(); #1;
    chk("R5 no request for zero size", int'(req_valid), 0);
    step(); #1;
    chk("R5 next store presented", int'(req_addr), 'h201);
    chk("R5 next store valid", int'(req_valid), 1);
    step(); #1;
    chk("R5 zero size released", int'(sq_used), 1);
    do_resp(slot[1]);
    step(); #1;
    chk("R6 drained", int'(sq_used), 0);

    // random rounds against a model
    for (int r = 0; r < 25; r++) begin
      int base, n, c, s, survivors, got, pidx;
      bit sq_on, pend, exp_block;
      int sizes [4];
      int expq [$];
      base = 40 + r * 8;
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) do_alloc(base + i, slot[i]);
      for (int i = 0; i < n; i++) begin
        sizes[i] = (($urandom % 4) == 0) ? 0 : 4;
        do_exec(slot[i], base * 16 + i, base + i, sizes[i]);
      end
      c = int'($urandom % (n + 1));
      s = int'($urandom % (n + 1));
      sq_on = 1'($urandom % 2);
      commit_valid = (c > 0); commit_seq = SEQ_W'(base + c - 1);
      squash_valid = sq_on;   squash_seq = SEQ_W'(base + s - 1);
      expq.delete();
      for (int i = 0; i < c; i++) if (sizes[i] != 0) expq.push_back(base * 16 + i);
      survivors = sq_on ? ((c > s) ? c : s) : n;
      step(); #1;
      chk("R8 survivors after commit/squash", int'(sq_used), survivors);
      got = 0; pend = 0; pidx = 0; exp_block = 0;
      for (int cyc = 0; cyc < 60; cyc++) begin
        req_ready   = (($urandom % 3) != 0);
        cache_retry = 1'($urandom % 2);
        if (pend) begin resp_valid = 1'b1; resp_idx = IDX_W'(pidx); end
        pend = 0;
        #1;
        if (exp_block && !cache_retry) chk("R4 silent while blocked", int'(req_valid), 0);
        if (req_valid) begin
          if (got < expq.size()) chk("R3 program order", int'(req_addr), expq[got]);
          else chk("R3 unexpected write", 1, 0);
          if (req_ready) begin
            got++; pend = 1; pidx = int'(req_idx); exp_block = 0;
          end else begin
            exp_block = 1;
          end
        end
        step();
      end
      if (pend) do_resp(IDX_W'(pidx));
      chk("R3 all committed written", got, expq.size());
      squash_valid = 1'b1; squash_seq = SEQ_W'(base - 1);
      step(); step(); step(); #1;
      chk("R6 round drained", int'(sq_used), 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule